// File: doc/BRIEF.md
# Multi-Stack Buffer Descriptor Manager

This block holds a set of independent last-in-first-out stacks of buffer addresses. Software or hardware reaches them through one memory-mapped request port. A store pushes a buffer virtual address onto the stack that the access address names. A load pops the top entry of the named stack and returns a packed 64-bit descriptor. The descriptor carries the address, the stack index, a hardware-buffer flag, the stack's configured size code and a two-bit validity code.

A pop from an empty stack is a normal outcome, not an error. It returns a descriptor that holds only the "nothing available" validity code. The size code of each stack comes from a small configuration port, not from the written data. A push to a full stack is dropped and raises a sticky per-stack overflow flag. One request is serviced per cycle. A pop's descriptor appears on the response port in the cycle after the request.

Top module: `buf_stack_mgr`

## Requirements
- R1: An access is handled only when `req_addr[28:26]` equals 6. Any other region value produces no response and changes no stack. The stack number is `req_addr[7:3]`, and all other address bits are ignored.
- R2: A handled store pushes `req_wdata[41:7]` as the buffer address. All other data bits (index, flag, size and validity fields) have no effect on what a later pop returns.
- R3: A handled load pops the most recently pushed entry of its stack. `rsp_valid` is high for exactly the cycle after the request. Stores never produce a response.
- R4: A successful pop returns `rsp_rdata` laid out as follows. Bits [63:62] hold 0. Bits [61:59] hold the stack's size code, and bit 58 is 1. Bits [52:48] hold the stack number and bits [41:7] hold the address. All other bits are 0.
- R5: A pop from an empty stack returns `rsp_rdata` with bits [63:62] = 3 and every other bit 0. The stack stays empty.
- R6: `cfg_we` writes `cfg_size` as the size code of stack `cfg_stack`. Later pops from that stack report this code. Every size code is 0 after reset.
- R7: A push to a stack that already holds DEPTH entries is dropped and leaves the stack contents unchanged. It sets bit s of `ovf_flags`, and only reset clears that bit.
- R8: Stacks are independent. Traffic on one stack never changes what another stack returns.
- R9: A stack number at or above N_STACKS is ignored by requests and by configuration writes.
- R10: After reset all stacks are empty, `ovf_flags` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store (push), 0 = load (pop) |
| req_addr | input | 32 | Access address (region and stack fields) |
| req_wdata | input | 64 | Store data; buffer address in bits [41:7] |
| rsp_valid | output | 1 | Pop response valid, one cycle after the load |
| rsp_rdata | output | 64 | Pop descriptor; 0 when no response |
| cfg_we | input | 1 | Size-code configuration write strobe |
| cfg_stack | input | 5 | Stack whose size code is written |
| cfg_size | input | 3 | Size code to store |
| ovf_flags | output | N_STACKS | Sticky per-stack dropped-push flags |

## Verification
The bench builds the block with N_STACKS = 8 and DEPTH = 4. The shallow stacks let random traffic reach the full and empty states often, so overflow drops and empty-stack pops occur many times in a short run. With only eight stacks, the 5-bit stack field can also name stacks 8 to 31, which exercises the out-of-range path. Misdirected region values and junk in the ignored data fields are mixed into the random traffic.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 64;
    localparam int VA_W       = 35;
    localparam int VA_LSB     = 7;
    localparam int STK_LSB    = 3;
    localparam int STK_W      = 5;
    localparam int REGION_LSB = 26;
    localparam int REGION_W   = 3;
    localparam logic [REGION_W-1:0] REGION_ID = 3'd6;

    typedef enum logic [1:0] {
        VC_OK   = 2'd0,
        VC_NONE = 2'd3
    } vcode_e;

    typedef struct packed {
        vcode_e           code;
        logic [2:0]       size;
        logic             hwb;
        logic [4:0]       rsv_hi;
        logic [STK_W-1:0] sidx;
        logic [5:0]       rsv_mid;
        logic [VA_W-1:0]  va;
        logic [6:0]       rsv_lo;
    } desc_t;

    typedef struct packed {
        logic             hit;
        logic             push;
        logic             pop;
        logic [STK_W-1:0] stack;
    } req_t;

    function automatic desc_t make_desc(input logic ok, input logic [STK_W-1:0] sidx,
                                        input logic [2:0] size, input logic [VA_W-1:0] va);
        desc_t d;
        d = '0;
        if (ok) begin
            d.code = VC_OK;
            d.size = size;
            d.hwb  = 1'b1;
            d.sidx = sidx;
            d.va   = va;
        end else begin
            d.code = VC_NONE;
        end
        return d;
    endfunction
endpackage

// File: rtl/bsm_decode.sv
module bsm_decode
    import bsm_pkg::*;
#(
    parameter int N_STACKS = 32
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output req_t              dec
);
    logic [STK_W-1:0]    stk;
    logic [REGION_W-1:0] region;
    logic                in_range;

    assign stk    = req_addr[STK_LSB +: STK_W];
    assign region = req_addr[REGION_LSB +: REGION_W];

    generate
        if (N_STACKS >= (1 << STK_W)) begin : g_all
            assign in_range = 1'b1;
        end else begin : g_cmp
            assign in_range = (stk < STK_W'(N_STACKS));
        end
    endgenerate

    always_comb begin
        dec.hit   = req_valid && (region == REGION_ID) && in_range;
        dec.push  = dec.hit && req_write;
        dec.pop   = dec.hit && !req_write;
        dec.stack = stk;
    end
endmodule

// File: rtl/bsm_size_cfg.sv
module bsm_size_cfg
    import bsm_pkg::*;
#(
    parameter int N_STACKS = 32,
    localparam int SIDX_W  = (N_STACKS > 1) ? $clog2(N_STACKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [STK_W-1:0]  cfg_stack,
    input  logic [2:0]        cfg_size,
    input  logic [SIDX_W-1:0] rd_sel,
    output logic [2:0]        rd_size
);
    logic [2:0] size_q [N_STACKS];
    logic       cfg_ok;

    generate
        if (N_STACKS >= (1 << STK_W)) begin : g_all
            assign cfg_ok = cfg_we;
        end else begin : g_cmp
            assign cfg_ok = cfg_we && (cfg_stack < STK_W'(N_STACKS));
        end
    endgenerate

    for (genvar g = 0; g < N_STACKS; g++) begin : g_size
        always_ff @(posedge clk) begin
            if (rst)
                size_q[g] <= 3'd0;
            else if (cfg_ok && (cfg_stack[SIDX_W-1:0] == SIDX_W'(g)))
                size_q[g] <= cfg_size;
        end
    end

    assign rd_size = size_q[rd_sel];
endmodule

// File: rtl/bsm_stack_bank.sv
module bsm_stack_bank
    import bsm_pkg::*;
#(
    parameter int N_STACKS = 32,
    parameter int DEPTH    = 16,
    localparam int SIDX_W  = (N_STACKS > 1) ? $clog2(N_STACKS) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int MEM_N   = N_STACKS * DEPTH,
    localparam int MEM_AW  = (MEM_N > 1) ? $clog2(MEM_N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic                pop,
    input  logic [SIDX_W-1:0]   sel,
    input  logic [VA_W-1:0]     wva,
    output logic                rd_ok,
    output logic [VA_W-1:0]     rd_va,
    output logic [N_STACKS-1:0] ovf
);
    logic [CNT_W-1:0]  cnt [N_STACKS];
    logic [VA_W-1:0]   mem [MEM_N];
    logic [CNT_W-1:0]  cur;
    logic              full;
    logic              empty;
    logic [MEM_AW-1:0] wr_idx;
    logic [MEM_AW-1:0] rd_idx;

    always_comb begin
        cur    = cnt[sel];
        full   = (cur == CNT_W'(DEPTH));
        empty  = (cur == '0);
        wr_idx = MEM_AW'(int'(sel) * DEPTH + int'(cur));
        rd_idx = MEM_AW'(int'(sel) * DEPTH + int'(cur) - 1);
    end

    for (genvar g = 0; g < N_STACKS; g++) begin : g_stk
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
                ovf[g] <= 1'b0;
            end else if (sel == SIDX_W'(g)) begin
                if (push) begin
                    if (full) ovf[g] <= 1'b1;
                    else      cnt[g] <= cnt[g] + 1'b1;
                end else if (pop && !empty) begin
                    cnt[g] <= cnt[g] - 1'b1;
                end
            end
        end

        p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            $past(ovf[g]) |-> ovf[g]);
        p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
            (push && sel == SIDX_W'(g) && cnt[g] == CNT_W'(DEPTH))
            |=> (ovf[g] && $stable(cnt[g])));
        p_other_stack_r8: assert property (@(posedge clk) disable iff (rst)
            ((push || pop) && sel != SIDX_W'(g)) |=> $stable(cnt[g]));
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_idx] <= wva;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok <= 1'b0;
            rd_va <= '0;
        end else begin
            rd_ok <= pop && !empty;
            rd_va <= (pop && !empty) ? mem[rd_idx] : '0;
        end
    end

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> !rd_ok);
endmodule

// File: rtl/buf_stack_mgr.sv
module buf_stack_mgr
    import bsm_pkg::*;
#(
    parameter int N_STACKS = 32,
    parameter int DEPTH    = 16,
    localparam int SIDX_W  = (N_STACKS > 1) ? $clog2(N_STACKS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [31:0]         req_addr,
    input  logic [63:0]         req_wdata,
    output logic                rsp_valid,
    output logic [63:0]         rsp_rdata,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_stack,
    input  logic [2:0]          cfg_size,
    output logic [N_STACKS-1:0] ovf_flags
);
    req_t             dec;
    logic [SIDX_W-1:0] sel;
    logic [2:0]       size_now;
    logic             rd_ok;
    logic [VA_W-1:0]  rd_va;
    logic             rsp_q;
    logic [STK_W-1:0] stk_q;
    logic [2:0]       size_q;
    desc_t            desc;

    assign sel = dec.stack[SIDX_W-1:0];

    bsm_decode #(.N_STACKS(N_STACKS)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    bsm_size_cfg #(.N_STACKS(N_STACKS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_stack (cfg_stack),
        .cfg_size  (cfg_size),
        .rd_sel    (sel),
        .rd_size   (size_now)
    );

    bsm_stack_bank #(.N_STACKS(N_STACKS), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .push  (dec.push),
        .pop   (dec.pop),
        .sel   (sel),
        .wva   (req_wdata[VA_LSB +: VA_W]),
        .rd_ok (rd_ok),
        .rd_va (rd_va),
        .ovf   (ovf_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= 1'b0;
            stk_q  <= '0;
            size_q <= '0;
        end else begin
            rsp_q  <= dec.pop;
            stk_q  <= dec.stack;
            size_q <= size_now;
        end
    end

    assign desc      = make_desc(rd_ok, stk_q, size_q, rd_va);
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rsp_q ? desc : '0;

    p_rsp_timing_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));
    p_region_gate_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_addr[REGION_LSB +: REGION_W]) == REGION_ID));
    p_hwb_set_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rdata[63:62] == 2'd0) |-> rsp_rdata[58]);
    p_none_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rdata[63:62] == 2'd3) |-> (rsp_rdata[61:0] == '0));
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_rdata == '0));
endmodule

// File: tb/sim_buf_stack_mgr.sv
module sim_buf_stack_mgr;
    localparam int NS = 8;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [31:0]   req_addr  = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_stack = '0;
    logic [2:0]    cfg_size  = '0;
    logic [NS-1:0] ovf_flags;

    int n_chk  = 0;
    int n_fail = 0;

    logic [34:0]   m_mem  [NS][DP];
    int            m_cnt  [NS];
    logic [2:0]    m_size [NS];
    logic [NS-1:0] m_ovf;

    always #5 clk = ~clk;

    buf_stack_mgr #(.N_STACKS(NS), .DEPTH(DP)) u0 (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_wdata,
        .rsp_valid, .rsp_rdata, .cfg_we, .cfg_stack, .cfg_size, .ovf_flags
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int s, input logic [2:0] region);
        logic [31:0] a;
        a = $urandom;
        a[7:3]   = s[4:0];
        a[28:26] = region;
        return a;
    endfunction

    function automatic logic [63:0] exp_desc(input int s, input logic [2:0] sz, input logic [34:0] va);
        logic [63:0] d;
        d = '0;
        d[61:59] = sz;
        d[58]    = 1'b1;
        d[52:48] = s[4:0];
        d[41:7]  = va;
        return d;
    endfunction

    function automatic logic [34:0] rnd_va();
        logic [63:0] r;
        r = {$urandom, $urandom};
        return r[34:0];
    endfunction

    task automatic do_push(input int s, input logic [2:0] region, input logic [34:0] va);
        logic [63:0] w;
        @(negedge clk);
        w = {$urandom, $urandom};
        w[41:7] = va;
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = mk_addr(s, region); req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        if (region == 3'd6 && s < NS) begin
            if (m_cnt[s] == DP) m_ovf[s] = 1'b1;
            else begin m_mem[s][m_cnt[s]] = va; m_cnt[s]++; end
        end
        chk(rsp_valid == 1'b0, "R3 store gives no response", 64'(rsp_valid), 64'd0);
        chk(ovf_flags == m_ovf, "R7 overflow flags", 64'(ovf_flags), 64'(m_ovf));
    endtask

    task automatic do_pop(input int s, input logic [2:0] region, input string req);
        logic [63:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = mk_addr(s, region); req_wdata = {$urandom, $urandom};
        @(negedge clk);
        req_valid = 1'b0;
        if (region == 3'd6 && s < NS) begin
            if (m_cnt[s] > 0) begin
                m_cnt[s]--;
                e = exp_desc(s, m_size[s], m_mem[s][m_cnt[s]]);
            end else begin
                e = 64'd3 << 62;
            end
            chk(rsp_valid == 1'b1, {req, " response valid"}, 64'(rsp_valid), 64'd1);
            chk(rsp_rdata == e, req, rsp_rdata, e);
        end else begin
            chk(rsp_valid == 1'b0, {req, " ignored access"}, 64'(rsp_valid), 64'd0);
        end
    endtask

    task automatic do_cfg(input int s, input logic [2:0] sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stack = s[4:0]; cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < NS) m_size[s] = sz;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NS; i++) begin m_cnt[i] = 0; m_size[i] = 3'd0; end
        m_ovf = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(ovf_flags == '0, "R10 ovf_flags after reset", 64'(ovf_flags), 64'd0);
        // R5: pop of empty stack
        do_pop(0, 3'd6, "R5 empty pop");
        // R6 R3 R4: config then LIFO order
        do_cfg(2, 3'd5);
        do_push(2, 3'd6, 35'h1_2345_6789);
        do_push(2, 3'd6, 35'h7_0000_0001);
        do_push(2, 3'd6, 35'h0_ABCD_EF01);
        do_pop(2, 3'd6, "R3 R4 R6 LIFO pop");
        do_pop(2, 3'd6, "R3 R4 LIFO pop");
        // R7: fill stack 1 and overflow it
        for (int i = 0; i < DP + 2; i++) do_push(1, 3'd6, rnd_va());
        chk(ovf_flags[1] == 1'b1, "R7 overflow set", 64'(ovf_flags), 64'(m_ovf));
        do_pop(1, 3'd6, "R7 top unchanged after drop");
        // R1: wrong region push and pop are ignored
        do_push(3, 3'd5, 35'h5_5555_5555);
        do_pop(3, 3'd2, "R1 wrong region pop");
        do_pop(3, 3'd6, "R1 stack untouched");
        // R9: out-of-range stack and config
        do_push(9, 3'd6, 35'h1);
        do_cfg(12, 3'd7);
        do_pop(9, 3'd6, "R9 out-of-range pop");
        // R2: junk data fields do not reach the descriptor
        do_cfg(4, 3'd7);
        do_push(4, 3'd6, 35'h4_0000_0000);
        do_pop(4, 3'd6, "R2 ignored write fields");
        // R8: random traffic across stacks, model per stack
        for (int i = 0; i < 600; i++) begin
            int s;
            int op;
            logic [2:0] rg;
            s  = int'($urandom_range(0, NS + 1));
            op = int'($urandom_range(0, 9));
            rg = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 5)) : 3'd6;
            if (op < 5)       do_push(s, rg, rnd_va());
            else if (op < 9)  do_pop(s, rg, "R8 random pop");
            else              do_cfg(s, 3'($urandom_range(0, 7)));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule